// File: doc/BRIEF.md
# Bank-Sorted Request Buffer with Row-Hit Lookahead

This block holds memory requests that wait for a DRAM bank. Every accepted request carries a bank index, a row, a write flag and a tag, all decoded upstream. Requests are kept in one shared, age-ordered storage of `MAX_TXN` slots. Each bank sees its own queue, formed by the slots whose bank field matches, in order of arrival. A bank machine fetches its next request by bank index. The buffer answers in the same cycle and drops the entry at the next clock edge. When an entry leaves from the middle, the entries behind it move down one slot, so age order is never lost.

For adaptive page-policy decisions, each bank gets two live status bits. One says the bank has work queued. The other says a queued request targets the row the bank has open right now. The `MODE` parameter sets how far both the fetch and this row-hit check look. In strict FIFO mode only the bank's oldest entry counts. In FR-FCFS mode every queued entry of the bank is checked. If the bank is activated, the oldest matching entry is served before older entries that miss.

A three-state occupancy controller sets input readiness. Its states are EMPTY, PARTIAL and FULL. The transitions are FILL (EMPTY to PARTIAL on the first store), TOP (PARTIAL to FULL when the count reaches `MAX_TXN`), FREE (FULL to PARTIAL on a fetch) and DRAIN (PARTIAL to EMPTY when the last entry leaves). EMPTY goes straight to FULL only when `MAX_TXN` is 1.

Top module: `rq_bank_queue`

## Requirements
- R1: A request accepted with bank index b can be fetched only with `fetch_bank` = b. Fetching any other bank never returns it.
- R2: In FIFO mode, a fetch of a non-empty bank returns that bank's oldest entry in the same cycle (`fetch_valid` high, with its row, write flag and tag). The entry is gone after the next rising edge. `fetch_act` has no effect.
- R3: A fetch of a bank with no queued entry gives `fetch_valid` low and removes nothing.
- R4: `pend[b]` is high exactly when bank b has at least one queued entry. It rises in the cycle after the accepting edge.
- R5: In FIFO mode, `hit_pend[b]` is high only when bank b's oldest entry has the row `open_rows[b*ROW_W +: ROW_W]`. A match in a younger entry does not set it.
- R6: In FR-FCFS mode, `hit_pend[b]` is high when any queued entry of bank b has the row `open_rows[b*ROW_W +: ROW_W]`.
- R7: In FR-FCFS mode with `fetch_act` high, a fetch returns the oldest entry of the bank whose row equals the bank's open row. If none matches, or if `fetch_act` is low, it returns the bank's oldest entry.
- R8: `in_ready` is low exactly when `MAX_TXN` entries are stored in total. A request offered while `in_ready` is low is dropped and never fetched.
- R9: When an entry is removed from the middle of a bank's queue, the remaining entries keep their relative age order.
- R10: A store and a fetch in the same cycle both take effect, and the total count stays exact: it never exceeds `MAX_TXN`.
- R11: After reset, `in_ready` is high and all `pend` and `hit_pend` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Buffer can accept a request |
| in_bank | input | BANK_W | Bank index of offered request |
| in_row | input | ROW_W | Row of offered request |
| in_write | input | 1 | 1 = write, 0 = read |
| in_tag | input | TAG_W | Request identifier |
| fetch_req | input | 1 | Bank machine asks for its next request |
| fetch_bank | input | BANK_W | Bank being fetched for |
| fetch_act | input | 1 | That bank has a row open |
| open_rows | input | NUM_BANKS*ROW_W | Open row per bank, bank b at bits b*ROW_W |
| fetch_valid | output | 1 | A request is returned this cycle |
| fetch_row | output | ROW_W | Row of returned request |
| fetch_write | output | 1 | Write flag of returned request |
| fetch_tag | output | TAG_W | Tag of returned request |
| pend | output | NUM_BANKS | Per-bank request-pending |
| hit_pend | output | NUM_BANKS | Per-bank row-hit-pending |

## Verification
The fetch answer is combinational and due in the same cycle as `fetch_req`. Its removal, a store's effect on `pend`, `hit_pend` and `in_ready`, and any change in occupancy show up one edge later. The bench drives all inputs on the falling edge and reads the fetch answer 2 ns later, before the rising edge that commits it. It reads the status bits 1 ns after that rising edge. One FIFO instance and one FR-FCFS instance get the same stimulus, so the two hit scopes and the two fetch choices are compared on the same queue contents.

// File: rtl/rq_pkg.sv
package rq_pkg;

    typedef enum logic {
        MODE_FIFO   = 1'b0,
        MODE_FRFCFS = 1'b1
    } sched_mode_e;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_e;

endpackage

// File: rtl/rq_entry_store.sv
module rq_entry_store #(
    parameter int DEPTH  = 8,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 8,
    parameter int TAG_W  = 8,
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          st_en,
    input  logic [BANK_W-1:0]             st_bank,
    input  logic [ROW_W-1:0]              st_row,
    input  logic                          st_wr,
    input  logic [TAG_W-1:0]              st_tag,
    input  logic                          rm_en,
    input  logic [IDX_W-1:0]              rm_idx,
    output logic [DEPTH-1:0]              q_vld,
    output logic [DEPTH-1:0][BANK_W-1:0]  q_bank,
    output logic [DEPTH-1:0][ROW_W-1:0]   q_row,
    output logic [DEPTH-1:0]              q_wr,
    output logic [DEPTH-1:0][TAG_W-1:0]   q_tag,
    output logic [CNT_W-1:0]              count_next
);

    logic [CNT_W-1:0]             count;
    logic [CNT_W-1:0]             wr_pos;
    logic [DEPTH-1:0][BANK_W-1:0] n_bank;
    logic [DEPTH-1:0][ROW_W-1:0]  n_row;
    logic [DEPTH-1:0]             n_wr;
    logic [DEPTH-1:0][TAG_W-1:0]  n_tag;

    // Slot where a new entry lands once the removal has closed its gap.
    assign wr_pos     = count - (rm_en ? CNT_W'(1) : CNT_W'(0));
    assign count_next = wr_pos + (st_en ? CNT_W'(1) : CNT_W'(0));

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            q_vld[i] = (CNT_W'(i) < count);
        end
    end

    always_comb begin
        n_bank = q_bank;
        n_row  = q_row;
        n_wr   = q_wr;
        n_tag  = q_tag;
        // Compaction: every slot at or above the removed one pulls from above.
        for (int i = 0; i < DEPTH - 1; i++) begin
            if (rm_en && (IDX_W'(i) >= rm_idx)) begin
                n_bank[i] = q_bank[i+1];
                n_row[i]  = q_row[i+1];
                n_wr[i]   = q_wr[i+1];
                n_tag[i]  = q_tag[i+1];
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (st_en && (CNT_W'(i) == wr_pos)) begin
                n_bank[i] = st_bank;
                n_row[i]  = st_row;
                n_wr[i]   = st_wr;
                n_tag[i]  = st_tag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            q_bank <= '0;
            q_row  <= '0;
            q_wr   <= '0;
            q_tag  <= '0;
        end else begin
            count  <= count_next;
            q_bank <= n_bank;
            q_row  <= n_row;
            q_wr   <= n_wr;
            q_tag  <= n_tag;
        end
    end

endmodule

// File: rtl/rq_bank_scan.sv
module rq_bank_scan #(
    parameter int DEPTH   = 8,
    parameter int BANK_W  = 2,
    parameter int ROW_W   = 8,
    parameter int IDX_W   = 3,
    parameter int BANK_ID = 0
) (
    input  logic [DEPTH-1:0]             q_vld,
    input  logic [DEPTH-1:0][BANK_W-1:0] q_bank,
    input  logic [DEPTH-1:0][ROW_W-1:0]  q_row,
    input  logic [ROW_W-1:0]             open_row,
    output logic                         pending,
    output logic [IDX_W-1:0]             head_idx,
    output logic                         head_hit,
    output logic                         any_hit,
    output logic [IDX_W-1:0]             hit_idx
);

    logic [DEPTH-1:0] mine;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mine[i] = q_vld[i] && (q_bank[i] == BANK_W'(BANK_ID));
        end
    end

    // Walk from youngest to oldest so the lowest (oldest) slot wins.
    always_comb begin
        head_idx = '0;
        hit_idx  = '0;
        any_hit  = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (mine[i]) begin
                head_idx = IDX_W'(i);
                if (q_row[i] == open_row) begin
                    hit_idx = IDX_W'(i);
                    any_hit = 1'b1;
                end
            end
        end
    end

    assign pending  = |mine;
    assign head_hit = pending && (q_row[head_idx] == open_row);

endmodule

// File: rtl/rq_occ_fsm.sv
module rq_occ_fsm
    import rq_pkg::*;
#(
    parameter int MAX_TXN = 8,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_next,
    output logic             ready
);

    occ_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            OCC_EMPTY: begin
                if (count_next == CNT_W'(MAX_TXN))  state_nx = OCC_FULL;   // only when MAX_TXN = 1
                else if (count_next != '0)          state_nx = OCC_PART;   // FILL
            end
            OCC_PART: begin
                if (count_next == '0)               state_nx = OCC_EMPTY;  // DRAIN
                else if (count_next == CNT_W'(MAX_TXN)) state_nx = OCC_FULL; // TOP
            end
            OCC_FULL: begin
                if (count_next == '0)               state_nx = OCC_EMPTY;
                else if (count_next != CNT_W'(MAX_TXN)) state_nx = OCC_PART; // FREE
            end
            default:                                state_nx = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OCC_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            OCC_EMPTY: ready = 1'b1;
            OCC_PART:  ready = 1'b1;
            OCC_FULL:  ready = 1'b0;
            default:   ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/rq_bank_queue.sv
module rq_bank_queue
    import rq_pkg::*;
#(
    parameter int          NUM_BANKS = 4,
    parameter int          MAX_TXN   = 8,
    parameter int          ROW_W     = 8,
    parameter int          TAG_W     = 8,
    parameter sched_mode_e MODE      = MODE_FIFO,
    localparam int         BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [BANK_W-1:0]            in_bank,
    input  logic [ROW_W-1:0]             in_row,
    input  logic                         in_write,
    input  logic [TAG_W-1:0]             in_tag,
    input  logic                         fetch_req,
    input  logic [BANK_W-1:0]            fetch_bank,
    input  logic                         fetch_act,
    input  logic [NUM_BANKS*ROW_W-1:0]   open_rows,
    output logic                         fetch_valid,
    output logic [ROW_W-1:0]             fetch_row,
    output logic                         fetch_write,
    output logic [TAG_W-1:0]             fetch_tag,
    output logic [NUM_BANKS-1:0]         pend,
    output logic [NUM_BANKS-1:0]         hit_pend
);

    localparam int IDX_W = (MAX_TXN > 1) ? $clog2(MAX_TXN) : 1;
    localparam int CNT_W = $clog2(MAX_TXN + 1);

    logic [MAX_TXN-1:0]             q_vld;
    logic [MAX_TXN-1:0][BANK_W-1:0] q_bank;
    logic [MAX_TXN-1:0][ROW_W-1:0]  q_row;
    logic [MAX_TXN-1:0]             q_wr;
    logic [MAX_TXN-1:0][TAG_W-1:0]  q_tag;
    logic [CNT_W-1:0]               count_next;

    logic [NUM_BANKS-1:0]            head_hit_v;
    logic [NUM_BANKS-1:0]            any_hit_v;
    logic [NUM_BANKS-1:0][IDX_W-1:0] head_idx_v;
    logic [NUM_BANKS-1:0][IDX_W-1:0] hit_idx_v;

    logic             st_en;
    logic [IDX_W-1:0] pick_idx;

    assign st_en = in_valid && in_ready;

    rq_entry_store #(
        .DEPTH (MAX_TXN),
        .BANK_W(BANK_W),
        .ROW_W (ROW_W),
        .TAG_W (TAG_W),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_en     (st_en),
        .st_bank   (in_bank),
        .st_row    (in_row),
        .st_wr     (in_write),
        .st_tag    (in_tag),
        .rm_en     (fetch_valid),
        .rm_idx    (pick_idx),
        .q_vld     (q_vld),
        .q_bank    (q_bank),
        .q_row     (q_row),
        .q_wr      (q_wr),
        .q_tag     (q_tag),
        .count_next(count_next)
    );

    rq_occ_fsm #(
        .MAX_TXN(MAX_TXN),
        .CNT_W  (CNT_W)
    ) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_next(count_next),
        .ready     (in_ready)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rq_bank_scan #(
            .DEPTH  (MAX_TXN),
            .BANK_W (BANK_W),
            .ROW_W  (ROW_W),
            .IDX_W  (IDX_W),
            .BANK_ID(b)
        ) u_scan (
            .q_vld   (q_vld),
            .q_bank  (q_bank),
            .q_row   (q_row),
            .open_row(open_rows[b*ROW_W +: ROW_W]),
            .pending (pend[b]),
            .head_idx(head_idx_v[b]),
            .head_hit(head_hit_v[b]),
            .any_hit (any_hit_v[b]),
            .hit_idx (hit_idx_v[b])
        );

        if (MODE == MODE_FRFCFS) begin : g_wide
            assign hit_pend[b] = any_hit_v[b];
        end else begin : g_head
            assign hit_pend[b] = head_hit_v[b];
        end
    end

    if (MODE == MODE_FRFCFS) begin : g_pick_fr
        assign pick_idx = (fetch_act && any_hit_v[fetch_bank]) ? hit_idx_v[fetch_bank]
                                                               : head_idx_v[fetch_bank];
    end else begin : g_pick_fifo
        logic unused_act;
        assign unused_act = fetch_act;
        assign pick_idx   = head_idx_v[fetch_bank];
    end

    assign fetch_valid = fetch_req && pend[fetch_bank];
    assign fetch_row   = q_row[pick_idx];
    assign fetch_write = q_wr[pick_idx];
    assign fetch_tag   = q_tag[pick_idx];

endmodule

// File: rtl/rq_bank_queue_chk.sv
module rq_bank_queue_chk
    import rq_pkg::*;
#(
    parameter int          NUM_BANKS = 4,
    parameter int          MAX_TXN   = 8,
    parameter int          ROW_W     = 8,
    parameter int          TAG_W     = 8,
    parameter sched_mode_e MODE      = MODE_FIFO,
    localparam int         BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       in_ready,
    input logic [BANK_W-1:0]          in_bank,
    input logic                       fetch_req,
    input logic [BANK_W-1:0]          fetch_bank,
    input logic                       fetch_act,
    input logic [NUM_BANKS*ROW_W-1:0] open_rows,
    input logic                       fetch_valid,
    input logic [ROW_W-1:0]           fetch_row,
    input logic [NUM_BANKS-1:0]       pend,
    input logic [NUM_BANKS-1:0]       hit_pend
);

    localparam int CNT_W = $clog2(MAX_TXN + 1) + 1;

    logic [CNT_W-1:0] occ;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ <= '0;
        else        occ <= occ + ((in_valid && in_ready) ? CNT_W'(1) : CNT_W'(0))
                               - (fetch_valid ? CNT_W'(1) : CNT_W'(0));
    end

    p_ready_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == (occ < CNT_W'(MAX_TXN)));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(MAX_TXN));

    p_empty_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !pend[fetch_bank]) |-> !fetch_valid);

    p_fetch_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> fetch_req);

    p_store_sets_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> pend[$past(in_bank)]);

    p_idle_no_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> (pend == '0));

    p_hit_needs_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_pend & ~pend) == '0);

    p_fr_hit_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MODE_FRFCFS && fetch_valid && fetch_act && hit_pend[fetch_bank])
        |-> (fetch_row == open_rows[fetch_bank*ROW_W +: ROW_W]));

endmodule

bind rq_bank_queue rq_bank_queue_chk #(
    .NUM_BANKS(NUM_BANKS),
    .MAX_TXN  (MAX_TXN),
    .ROW_W    (ROW_W),
    .TAG_W    (TAG_W),
    .MODE     (MODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_bank    (in_bank),
    .fetch_req  (fetch_req),
    .fetch_bank (fetch_bank),
    .fetch_act  (fetch_act),
    .open_rows  (open_rows),
    .fetch_valid(fetch_valid),
    .fetch_row  (fetch_row),
    .pend       (pend),
    .hit_pend   (hit_pend)
);

// File: tb/tb_rq_bank_queue.sv
module tb_rq_bank_queue;
    import rq_pkg::*;

    localparam int NB  = 4;
    localparam int MAX = 8;
    localparam int RW  = 8;
    localparam int TW  = 8;
    localparam int BW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [BW-1:0] in_bank = '0;
    logic [RW-1:0] in_row = '0;
    logic          in_write = 1'b0;
    logic [TW-1:0] in_tag = '0;
    logic          fetch_req = 1'b0;
    logic [BW-1:0] fetch_bank = '0;
    logic          fetch_act = 1'b0;
    logic [NB*RW-1:0] open_rows = '0;

    logic          rdy_a, fv_a, fw_a;
    logic [RW-1:0] fr_a;
    logic [TW-1:0] ft_a;
    logic [NB-1:0] pend_a, hit_a;
    logic          rdy_b, fv_b, fw_b;
    logic [RW-1:0] fr_b;
    logic [TW-1:0] ft_b;
    logic [NB-1:0] pend_b, hit_b;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    rq_bank_queue #(.NUM_BANKS(NB), .MAX_TXN(MAX), .ROW_W(RW), .TAG_W(TW), .MODE(MODE_FIFO)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_a), .in_bank(in_bank),
        .in_row(in_row), .in_write(in_write), .in_tag(in_tag), .fetch_req(fetch_req),
        .fetch_bank(fetch_bank), .fetch_act(fetch_act), .open_rows(open_rows),
        .fetch_valid(fv_a), .fetch_row(fr_a), .fetch_write(fw_a), .fetch_tag(ft_a),
        .pend(pend_a), .hit_pend(hit_a));

    rq_bank_queue #(.NUM_BANKS(NB), .MAX_TXN(MAX), .ROW_W(RW), .TAG_W(TW), .MODE(MODE_FRFCFS)) dut_fr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_b), .in_bank(in_bank),
        .in_row(in_row), .in_write(in_write), .in_tag(in_tag), .fetch_req(fetch_req),
        .fetch_bank(fetch_bank), .fetch_act(fetch_act), .open_rows(open_rows),
        .fetch_valid(fv_b), .fetch_row(fr_b), .fetch_write(fw_b), .fetch_tag(ft_b),
        .pend(pend_b), .hit_pend(hit_b));

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic store(input int bank, input int row, input int tag, input bit wr);
        @(negedge clk);
        in_valid = 1'b1;
        in_bank  = BW'(bank);
        in_row   = RW'(row);
        in_tag   = TW'(tag);
        in_write = wr;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // Answer is read 2 ns after the falling edge, before the committing edge.
    task automatic fetch(input int bank, input bit act,
                         output int va, output int ta, output int vb, output int tb);
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_bank = BW'(bank);
        fetch_act  = act;
        #2;
        va = int'(fv_a); ta = int'(ft_a);
        vb = int'(fv_b); tb = int'(ft_b);
        @(posedge clk);
        #1 fetch_req = 1'b0;
    endtask

    task automatic set_open(input int bank, input int row);
        open_rows[bank*RW +: RW] = RW'(row);
    endtask

    task automatic t_reset;
        chk("R11", "ready fifo", int'(rdy_a), 1);
        chk("R11", "ready fr", int'(rdy_b), 1);
        chk("R11", "pend", int'({pend_a, pend_b}), 0);
        chk("R11", "hit", int'({hit_a, hit_b}), 0);
    endtask

    task automatic t_sort;
        int va, ta, vb, tb;
        store(2, 5, 1, 1'b1);
        chk("R4", "pend after store fifo", int'(pend_a), 4'b0100);
        chk("R4", "pend after store fr", int'(pend_b), 4'b0100);
        fetch(1, 1'b0, va, ta, vb, tb);
        chk("R3", "empty bank valid fifo", va, 0);
        chk("R1", "wrong bank valid fr", vb, 0);
        chk("R3", "pend kept", int'(pend_a), 4'b0100);
        @(negedge clk);
        fetch_req = 1'b1; fetch_bank = 2'd2; fetch_act = 1'b0;
        #2;
        chk("R1", "own bank valid", int'(fv_a), 1);
        chk("R2", "tag", int'(ft_a), 1);
        chk("R2", "row", int'(fr_a), 5);
        chk("R2", "write flag", int'(fw_a), 1);
        @(posedge clk);
        #1 fetch_req = 1'b0;
        chk("R4", "pend cleared fifo", int'(pend_a), 0);
        chk("R4", "pend cleared fr", int'(pend_b), 0);
    endtask

    task automatic t_hit_order;
        int va, ta, vb, tb;
        store(0, 3, 10, 1'b0);
        store(0, 7, 11, 1'b0);
        store(0, 3, 12, 1'b0);
        set_open(0, 7);
        #1;
        chk("R5", "fifo hit only at head", int'(hit_a[0]), 0);
        chk("R6", "fr hit anywhere", int'(hit_b[0]), 1);
        set_open(0, 9);
        #1;
        chk("R6", "fr no match", int'(hit_b[0]), 0);
        set_open(0, 3);
        #1;
        chk("R5", "fifo head match", int'(hit_a[0]), 1);
        set_open(0, 7);
        fetch(0, 1'b1, va, ta, vb, tb);
        chk("R2", "fifo oldest", ta, 10);
        chk("R7", "fr row hit first", tb, 11);
        #1;
        chk("R5", "fifo head now row7", int'(hit_a[0]), 1);
        chk("R6", "fr no row7 left", int'(hit_b[0]), 0);
        fetch(0, 1'b1, va, ta, vb, tb);
        chk("R2", "fifo second", ta, 11);
        chk("R9", "fr oldest after compaction", tb, 10);
        fetch(0, 1'b1, va, ta, vb, tb);
        chk("R9", "fifo last", ta, 12);
        chk("R9", "fr last", tb, 12);
        store(1, 4, 20, 1'b0);
        store(1, 6, 21, 1'b0);
        set_open(1, 6);
        fetch(1, 1'b0, va, ta, vb, tb);
        chk("R7", "fr inactive takes oldest", tb, 20);
        chk("R2", "fifo oldest", ta, 20);
        fetch(1, 1'b1, va, ta, vb, tb);
        chk("R7", "fr remaining", tb, 21);
        chk("R4", "all idle", int'({pend_a, pend_b}), 0);
    endtask

    task automatic t_capacity;
        int va, ta, vb, tb;
        for (int i = 0; i < MAX; i++) store(i % NB, i, 30 + i, 1'b0);
        chk("R8", "full ready fifo", int'(rdy_a), 0);
        chk("R8", "full ready fr", int'(rdy_b), 0);
        store(3, 0, 99, 1'b0);
        fetch(0, 1'b0, va, ta, vb, tb);
        chk("R8", "oldest bank0", ta, 30);
        chk("R8", "ready after fetch", int'(rdy_a), 1);
        // simultaneous store into bank0 and fetch from bank1
        @(negedge clk);
        in_valid = 1'b1; in_bank = 2'd0; in_row = 8'd0; in_tag = 8'd40;
        fetch_req = 1'b1; fetch_bank = 2'd1; fetch_act = 1'b0;
        #2;
        chk("R10", "fetch during store", int'(ft_a), 31);
        @(posedge clk);
        #1 begin in_valid = 1'b0; fetch_req = 1'b0; end
        chk("R10", "count held, ready", int'(rdy_a), 1);
        store(2, 0, 41, 1'b0);
        chk("R10", "count reaches max fifo", int'(rdy_a), 0);
        chk("R10", "count reaches max fr", int'(rdy_b), 0);
        fetch(0, 1'b0, va, ta, vb, tb); chk("R1", "b0 first", ta, 34);
        fetch(0, 1'b0, va, ta, vb, tb); chk("R10", "b0 stored during fetch", tb, 40);
        fetch(1, 1'b0, va, ta, vb, tb); chk("R1", "b1", ta, 35);
        fetch(2, 1'b0, va, ta, vb, tb); chk("R9", "b2 a", ta, 32);
        fetch(2, 1'b0, va, ta, vb, tb); chk("R9", "b2 b", ta, 36);
        fetch(2, 1'b0, va, ta, vb, tb); chk("R9", "b2 c", tb, 41);
        fetch(3, 1'b0, va, ta, vb, tb); chk("R1", "b3 a", ta, 33);
        fetch(3, 1'b0, va, ta, vb, tb); chk("R1", "b3 b", tb, 37);
        fetch(3, 1'b0, va, ta, vb, tb);
        chk("R8", "refused request absent fifo", va, 0);
        chk("R8", "refused request absent fr", vb, 0);
        chk("R4", "drained", int'({pend_a, pend_b}), 0);
        chk("R8", "ready again", int'(rdy_a & rdy_b), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sort();
        t_hit_order();
        t_capacity();
        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule